// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block walks an output frame pixel by pixel in raster order and gives, for each pixel, the word address at which that pixel must land in the destination buffer. The destination can be rotated by 0, 90, 180 or 270 degrees clockwise. It can also be stored in a tiled layout made of 8x8 blocks. A start pulse latches the frame geometry and the mode. Each accept strobe then moves the walk to the next pixel. A one-cycle done pulse marks the end of the frame.

The block does not move any data. A write engine beside it presents one pixel at a time, uses `addr` as the target, and raises `accept` when the write has been taken. The `last` output marks the final pixel of the frame. If the requested configuration is illegal, `cfg_err` reports it and no frame starts.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, `busy`, `last`, `done` and `cfg_err` are low, and `addr` is 0. `addr` stays 0 whenever `busy` is low.
- R2: A `start` while idle latches `width_m1`, `height_m1`, `rot` and `tile_en`. If the configuration is legal, `busy` is high in the next cycle and the walk sits at pixel (0,0). A `start` while busy, and any change of the configuration inputs while busy, have no effect on the running frame.
- R3: Each cycle with `busy` and `accept` both high moves x up by one. When x is at W-1, the same strobe instead sets x to 0 and moves y up by one. A busy cycle without `accept` holds the position and holds `addr`.
- R4: With `rot`=0 and `tile_en`=0, the address is y*W + x.
- R5: With `rot`=1 (90 degrees clockwise), the destination column is H-1-y and the destination row is x. The row pitch is H.
- R6: With `rot`=2 (180 degrees, not mirrored), the destination column is W-1-x and the destination row is H-1-y. The row pitch is W.
- R7: With `rot`=3 (270 degrees clockwise), the destination column is y and the destination row is W-1-x. The row pitch is H.
- R8: With `tile_en`=1, the row-pitch rule of R4 to R7 is replaced as follows. The tile index is (row/8)*(pitch/8) + col/8, and the address is tile_index*64 + (row%8)*8 + col%8.
- R9: `last` is high exactly while busy at pixel (W-1, H-1).
- R10: Accepting the last pixel clears `busy` and raises `done` for exactly one cycle, in the following cycle.
- R11: A `start` with `tile_en`=1 and W or H not a multiple of 8, or with `height_m1` above 511, sets `cfg_err` and leaves the block idle. The next legal `start` clears `cfg_err`.
- R12: A 1x1 frame has `last` high on its first pixel, which has address 0 in every rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (used only while idle) |
| accept | input | 1 | The current pixel has been taken |
| width_m1 | input | 9 | Output width minus one |
| height_m1 | input | 10 | Output height minus one |
| rot | input | 2 | Rotation: 0 none, 1 90 CW, 2 180, 3 270 CW |
| tile_en | input | 1 | 8x8 tiled destination layout |
| busy | output | 1 | A frame is in progress |
| addr | output | 18 | Destination word address of the current pixel |
| last | output | 1 | The current pixel is the final one |
| done | output | 1 | One-cycle frame completion pulse |
| cfg_err | output | 1 | The last start request was rejected |

## Verification
The assertions check several rules on every cycle. `done` is a single-cycle pulse that follows an accepted last pixel. `last` and `cfg_err` each agree with `busy`. A stalled cycle keeps the address steady. Every address stays below W*H.

The exact address for each pixel under each rotation and tile mode can only be shown by the bench's frames. The same holds for the raster order, for the rejection and recovery of illegal configurations, and for the 1x1 and 512-wide edges. Each of these is compared against an independently computed expected value.

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
  parameter int XW = 9,
  parameter int YW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             accept,
  input  logic [XW-1:0]    width_m1,
  input  logic [YW-1:0]    height_m1,
  input  logic [1:0]       rot,
  input  logic             tile_en,
  output logic             busy,
  output logic [2*XW-1:0]  addr,
  output logic             last,
  output logic             done,
  output logic             cfg_err
);
  localparam int AW = 2 * XW;
  localparam int PW = XW + 1;

  logic          busy_q, done_q, err_q, tile_q;
  logic [XW-1:0] x_q, y_q, wm1_q, hm1_q;
  logic [1:0]    rot_q;

  logic [XW-1:0] dc, dr;
  logic [PW-1:0] pitch;
  logic [AW-1:0] lin_addr, tile_idx, tile_addr;

  wire x_end = (x_q == wm1_q);
  wire y_end = (y_q == hm1_q);
  wire fin   = busy_q && x_end && y_end;

  wire too_tall  = |height_m1[YW-1:XW];
  wire misalign  = tile_en && ((width_m1[2:0] != 3'b111) || (height_m1[2:0] != 3'b111));
  wire bad_cfg   = too_tall || misalign;

  always_comb begin
    case (rot_q)
      2'd1: begin dc = hm1_q - y_q; dr = x_q;         pitch = PW'(hm1_q) + 1'b1; end
      2'd2: begin dc = wm1_q - x_q; dr = hm1_q - y_q; pitch = PW'(wm1_q) + 1'b1; end
      2'd3: begin dc = y_q;         dr = wm1_q - x_q; pitch = PW'(hm1_q) + 1'b1; end
      default: begin dc = x_q;      dr = y_q;         pitch = PW'(wm1_q) + 1'b1; end
    endcase
  end

  assign lin_addr  = AW'(dr) * AW'(pitch) + AW'(dc);
  assign tile_idx  = AW'(dr >> 3) * AW'(pitch >> 3) + AW'(dc >> 3);
  assign tile_addr = {tile_idx[AW-7:0], dr[2:0], dc[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tile_q <= 1'b0;
      rot_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      wm1_q  <= '0;
      hm1_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        if (bad_cfg) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          busy_q <= 1'b1;
          x_q    <= '0;
          y_q    <= '0;
          wm1_q  <= width_m1;
          hm1_q  <= height_m1[XW-1:0];
          rot_q  <= rot;
          tile_q <= tile_en;
        end
      end else if (busy_q && accept) begin
        if (fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (x_end) begin
          x_q <= '0;
          y_q <= y_q + 1'b1;
        end else begin
          x_q <= x_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign cfg_err = err_q;
  assign last    = fin;
  assign addr    = !busy_q ? '0 : (tile_q ? tile_addr : lin_addr);
endmodule

module fb_addr_gen_chk #(
  parameter int XW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            busy,
  input logic            last,
  input logic            done,
  input logic            cfg_err,
  input logic [2*XW-1:0] addr,
  input logic [XW-1:0]   wm1,
  input logic [XW-1:0]   hm1
);
  logic [2*XW+1:0] area;
  assign area = (($bits(area))'(wm1) + 1'b1) * (($bits(area))'(hm1) + 1'b1);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_follows_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last && accept));
  assert_last_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy);
  assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> (busy && $stable(addr)));
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((($bits(area))'(addr)) < area));
  assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr == '0));
endmodule

bind fb_addr_gen fb_addr_gen_chk #(.XW(XW)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .last(last),
  .done(done), .cfg_err(cfg_err), .addr(addr), .wm1(wm1_q), .hm1(hm1_q)
);

// File: tb/fb_addr_gen_tb.sv
module fb_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, accept = 1'b0, tile_en = 1'b0;
  logic [8:0]  width_m1 = '0;
  logic [9:0]  height_m1 = '0;
  logic [1:0]  rot = '0;
  logic        busy, last, done, cfg_err;
  logic [17:0] addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .width_m1(width_m1), .height_m1(height_m1), .rot(rot), .tile_en(tile_en),
    .busy(busy), .addr(addr), .last(last), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int x, int y, int w, int h, int r, bit t);
    int c, rw, p;
    case (r)
      1: begin c = h - 1 - y; rw = x;         p = h; end
      2: begin c = w - 1 - x; rw = h - 1 - y; p = w; end
      3: begin c = y;         rw = w - 1 - x; p = h; end
      default: begin c = x;   rw = y;         p = w; end
    endcase
    if (t) return ((rw / 8) * (p / 8) + c / 8) * 64 + (rw % 8) * 8 + (c % 8);
    return rw * p + c;
  endfunction

  task automatic run_frame(int w, int h, int r, bit t, bit poke, string tag);
    @(negedge clk);
    width_m1 = 9'(w - 1); height_m1 = 10'(h - 1); rot = 2'(r); tile_en = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, busy, 1);
    chk({tag, " R11 cfg_err cleared"}, cfg_err, 0);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int idx = y * w + x;
        if (idx % 3 == 2) begin
          accept = 1'b0;
          @(negedge clk);
          chk({tag, " R3 stall keeps busy"}, busy, 1);
        end
        chk({tag, " address"}, int'(addr), exp_addr(x, y, w, h, r, t));
        chk({tag, " R9 last"}, last, (x == w - 1 && y == h - 1));
        if (poke && idx == 1) begin
          start = 1'b1; width_m1 = 9'd0; height_m1 = 10'd0; rot = 2'd2; tile_en = 1'b1;
        end
        accept = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    accept = 1'b0;
    chk({tag, " R10 done pulse"}, done, 1);
    chk({tag, " R10 busy cleared"}, busy, 0);
    chk({tag, " R1 idle addr zero"}, int'(addr), 0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, done, 0);
  endtask

  task automatic test_reset();
    chk("R1 busy", busy, 0);
    chk("R1 last", last, 0);
    chk("R1 done", done, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 addr", int'(addr), 0);
  endtask

  task automatic test_bad_cfg();
    @(negedge clk);
    width_m1 = 9'd11; height_m1 = 10'd7; rot = 2'd0; tile_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 misaligned tile sets cfg_err", cfg_err, 1);
    chk("R11 misaligned tile stays idle", busy, 0);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    chk("R11 accept while rejected idle", busy, 0);
    chk("R11 done stays low", done, 0);
    width_m1 = 9'd3; height_m1 = 10'd512; tile_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 height above 512 sets cfg_err", cfg_err, 1);
    chk("R11 height above 512 stays idle", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_frame(5, 3, 0, 1'b0, 1'b1, "R4 R2");
    run_frame(4, 3, 1, 1'b0, 1'b0, "R5");
    run_frame(5, 3, 2, 1'b0, 1'b0, "R6");
    run_frame(3, 4, 3, 1'b0, 1'b0, "R7");
    test_bad_cfg();
    run_frame(16, 8, 0, 1'b1, 1'b0, "R8 rot0");
    run_frame(8, 16, 1, 1'b1, 1'b0, "R8 rot1");
    run_frame(16, 16, 2, 1'b1, 1'b0, "R8 rot2");
    run_frame(8, 16, 3, 1'b1, 1'b0, "R8 rot3");
    run_frame(1, 1, 0, 1'b0, 1'b0, "R12 rot0");
    run_frame(1, 1, 1, 1'b0, 1'b0, "R12 rot1");
    run_frame(1, 1, 3, 1'b0, 1'b0, "R12 rot3");
    run_frame(512, 2, 0, 1'b0, 1'b0, "R4 wide");
    run_frame(2, 512, 1, 1'b0, 1'b0, "R5 tall");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule